// File: doc/BRIEF.md
# Linked-List Sharer Directory Controller

This block is a coherence directory that records which caches hold a copy of each memory block. It does not keep a bit-vector of sharers. Instead it keeps one head pointer per block, and each sharer's entry carries a forward link and a backward link. Together these form a doubly linked chain. The per-cache link storage is modelled inside the block as a small table with one entry per block and node.

Caches present one request at a time. Each request is a read miss, a write miss or an eviction, and names a node and a block.

- A read miss puts the requester at the front of the chain.
- An eviction splices the evictor out by joining its two neighbours.
- A write miss walks the chain from front to back, one node per cycle. It emits an invalidation for every sharer other than the writer, then leaves the writer as the only member.

While a walk is running, a request for the same block is refused with a retry. A request for any other block is held off until the walk finishes.

The pointer value with all bits set means "no node". A chain whose head holds that value is empty.

Top module: `ll_sharer_dir`

FSM states and transitions:
- IDLE: accepts a request. A write goes to WALK. A read, an eviction or the reserved code goes to DONE.
- WALK: steps to the next node each cycle. When the cursor holds the null value, the writer becomes the sole member and the FSM moves to DONE.
- DONE: raises `done` for one cycle, then returns to IDLE.

## Requirements
- R1: After reset every block's chain is empty, `req_ready` is 1, and `done`, `inv_valid` and `retry` are 0.
- R2: A read miss (`req_op`=0) by a node not yet on the chain places it at the head, so a later walk visits nodes in reverse order of insertion.
- R3: A read miss by a node already on the block's chain leaves the chain unchanged.
- R4: A write miss (`req_op`=1) issues one invalidation per cycle for each chain member from head to tail. The writer itself is skipped, and `inv_blk` equals the requested block.
- R5: After a write miss completes, the block's chain holds only the writer.
- R6: An eviction (`req_op`=2) removes the node from the head, middle or tail position and keeps the rest in order. Evicting a node that is not on the chain changes nothing.
- R7: A read, an eviction or the reserved code raises `done` in the cycle after acceptance. A write raises it in the cycle after the walk reaches null. `done` lasts exactly one cycle.
- R8: During a walk, a request for the walked block sees `retry`=1 and `req_ready`=1, is consumed, and has no effect. A request for another block sees `req_ready`=0.
- R9: Operations on one block never change another block's chain.
- R10: Code 3 on `req_op` is accepted and completes with no change to any chain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_op | input | 2 | 0 read miss, 1 write miss, 2 eviction, 3 no action |
| req_node | input | PW | Requesting node id, below NODES |
| req_blk | input | BW | Block index |
| req_ready | output | 1 | Request taken this cycle |
| retry | output | 1 | Request refused because its block is being walked |
| inv_valid | output | 1 | Invalidation issued this cycle |
| inv_node | output | PW | Node to invalidate |
| inv_blk | output | BW | Block being invalidated |
| done | output | 1 | One-cycle completion pulse |

## Verification
The checker watches every cycle for the following:
- an invalidation never names the writer and always carries the walked block;
- a retry only ever answers a request for the walked block;
- `done` is a single-cycle pulse;
- `done` follows acceptance of a non-write request by exactly one cycle.

Chain contents are not visible at the ports, so ordering, duplicate suppression, splicing at each position and block isolation are shown only by the bench's scenarios. Each scenario reads the chain back through the invalidation sequence of a later write miss.

// File: rtl/ll_dir_pkg.sv
package ll_dir_pkg;
    typedef enum logic [1:0] {
        OP_RD  = 2'd0,
        OP_WR  = 2'd1,
        OP_EV  = 2'd2,
        OP_NOP = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_WALK = 2'd1,
        S_DONE = 2'd2
    } st_e;
endpackage

// File: rtl/ll_dir_store.sv
module ll_dir_store #(
    parameter int NODES  = 4,
    parameter int BLOCKS = 4,
    parameter int PW     = 3,
    parameter int BW     = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [BW-1:0] blk_i,
    input  logic [PW-1:0] node_i,
    input  logic [PW-1:0] cur_i,
    input  logic          ins_i,
    input  logic          del_i,
    input  logic          clr_i,
    input  logic          solo_i,
    output logic [PW-1:0] head_o,
    output logic [PW-1:0] nxt_o
);
    localparam int          NS  = 1 << PW;
    localparam int          BS  = 1 << BW;
    localparam logic [PW-1:0] NIL = {PW{1'b1}};

    logic [PW-1:0] head_q [BS];
    logic [PW-1:0] nxt_q  [BS][NS];
    logic [PW-1:0] prv_q  [BS][NS];
    logic [NS-1:0] mem_q  [BS];

    logic [PW-1:0] del_p, del_x;
    logic          node_on;

    assign head_o  = head_q[blk_i];
    assign nxt_o   = nxt_q[blk_i][cur_i];
    assign del_p   = prv_q[blk_i][node_i];
    assign del_x   = nxt_q[blk_i][node_i];
    assign node_on = mem_q[blk_i][node_i];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int b = 0; b < BS; b++) begin
                head_q[b] <= NIL;
                mem_q[b]  <= '0;
                for (int n = 0; n < NS; n++) begin
                    nxt_q[b][n] <= NIL;
                    prv_q[b][n] <= NIL;
                end
            end
        end else begin
            // front insertion, skipped when already linked
            if (ins_i && !node_on) begin
                nxt_q[blk_i][node_i] <= head_q[blk_i];
                prv_q[blk_i][node_i] <= NIL;
                mem_q[blk_i][node_i] <= 1'b1;
                if (head_q[blk_i] != NIL)
                    prv_q[blk_i][head_q[blk_i]] <= node_i;
                head_q[blk_i] <= node_i;
            end
            // splice out: join neighbours
            if (del_i && node_on) begin
                if (del_p == NIL) head_q[blk_i] <= del_x;
                else              nxt_q[blk_i][del_p] <= del_x;
                if (del_x != NIL) prv_q[blk_i][del_x] <= del_p;
                mem_q[blk_i][node_i] <= 1'b0;
                nxt_q[blk_i][node_i] <= NIL;
                prv_q[blk_i][node_i] <= NIL;
            end
            // walk step drops the visited node
            if (clr_i && cur_i != NIL) begin
                mem_q[blk_i][cur_i] <= 1'b0;
                nxt_q[blk_i][cur_i] <= NIL;
                prv_q[blk_i][cur_i] <= NIL;
            end
            // end of walk: writer alone
            if (solo_i) begin
                head_q[blk_i]        <= node_i;
                mem_q[blk_i][node_i] <= 1'b1;
                nxt_q[blk_i][node_i] <= NIL;
                prv_q[blk_i][node_i] <= NIL;
            end
        end
    end
endmodule

// File: rtl/ll_dir_ctrl.sv
module ll_dir_ctrl
    import ll_dir_pkg::*;
#(
    parameter int PW = 3,
    parameter int BW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [1:0]    req_op,
    input  logic [PW-1:0] req_node,
    input  logic [BW-1:0] req_blk,
    input  logic [PW-1:0] head_i,
    input  logic [PW-1:0] nxt_i,
    output logic          req_ready,
    output logic          retry,
    output logic          inv_valid,
    output logic [PW-1:0] inv_node,
    output logic [BW-1:0] inv_blk,
    output logic          done,
    output logic [BW-1:0] blk_o,
    output logic [PW-1:0] node_o,
    output logic [PW-1:0] cur_o,
    output logic          ins_o,
    output logic          del_o,
    output logic          clr_o,
    output logic          solo_o
);
    localparam logic [PW-1:0] NIL = {PW{1'b1}};

    st_e           state, state_nx;
    logic [BW-1:0] blk_q;
    logic [PW-1:0] node_q, cur_q;
    logic          accept;
    op_e           op;

    assign op     = op_e'(req_op);
    assign accept = (state == S_IDLE) && req_valid;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  if (req_valid) state_nx = (op == OP_WR) ? S_WALK : S_DONE;
            S_WALK:  if (cur_q == NIL) state_nx = S_DONE;
            S_DONE:  state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            blk_q  <= '0;
            node_q <= '0;
            cur_q  <= NIL;
        end else if (accept) begin
            blk_q  <= req_blk;
            node_q <= req_node;
            cur_q  <= head_i;
        end else if (state == S_WALK && cur_q != NIL) begin
            cur_q  <= nxt_i;
        end
    end

    always_comb begin
        blk_o     = (state == S_IDLE) ? req_blk  : blk_q;
        node_o    = (state == S_IDLE) ? req_node : node_q;
        cur_o     = cur_q;
        ins_o     = accept && (op == OP_RD);
        del_o     = accept && (op == OP_EV);
        clr_o     = (state == S_WALK) && (cur_q != NIL);
        solo_o    = (state == S_WALK) && (cur_q == NIL);
        inv_valid = (state == S_WALK) && (cur_q != NIL) && (cur_q != node_q);
        inv_node  = cur_q;
        inv_blk   = blk_q;
        retry     = (state == S_WALK) && req_valid && (req_blk == blk_q);
        req_ready = (state == S_IDLE) || retry;
        done      = (state == S_DONE);
    end
endmodule

// File: rtl/ll_sharer_dir.sv
module ll_sharer_dir #(
    parameter int NODES  = 4,
    parameter int BLOCKS = 4,
    localparam int PW    = $clog2(NODES + 1),
    localparam int BW    = (BLOCKS > 1) ? $clog2(BLOCKS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [1:0]    req_op,
    input  logic [PW-1:0] req_node,
    input  logic [BW-1:0] req_blk,
    output logic          req_ready,
    output logic          retry,
    output logic          inv_valid,
    output logic [PW-1:0] inv_node,
    output logic [BW-1:0] inv_blk,
    output logic          done
);
    logic [BW-1:0] s_blk;
    logic [PW-1:0] s_node, s_cur, s_head, s_nxt;
    logic          s_ins, s_del, s_clr, s_solo;

    ll_dir_ctrl #(.PW(PW), .BW(BW)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_op(req_op), .req_node(req_node), .req_blk(req_blk),
        .head_i(s_head), .nxt_i(s_nxt),
        .req_ready(req_ready), .retry(retry),
        .inv_valid(inv_valid), .inv_node(inv_node), .inv_blk(inv_blk), .done(done),
        .blk_o(s_blk), .node_o(s_node), .cur_o(s_cur),
        .ins_o(s_ins), .del_o(s_del), .clr_o(s_clr), .solo_o(s_solo)
    );

    ll_dir_store #(.NODES(NODES), .BLOCKS(BLOCKS), .PW(PW), .BW(BW)) u_store (
        .clk(clk), .rst_n(rst_n),
        .blk_i(s_blk), .node_i(s_node), .cur_i(s_cur),
        .ins_i(s_ins), .del_i(s_del), .clr_i(s_clr), .solo_i(s_solo),
        .head_o(s_head), .nxt_o(s_nxt)
    );
endmodule

// File: rtl/ll_dir_chk.sv
module ll_dir_chk #(
    parameter int NODES  = 4,
    parameter int BLOCKS = 4,
    localparam int PW    = $clog2(NODES + 1),
    localparam int BW    = (BLOCKS > 1) ? $clog2(BLOCKS) : 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic [1:0]    req_op,
    input logic [PW-1:0] req_node,
    input logic [BW-1:0] req_blk,
    input logic          req_ready,
    input logic          retry,
    input logic          inv_valid,
    input logic [PW-1:0] inv_node,
    input logic [BW-1:0] inv_blk,
    input logic          done
);
    logic [PW-1:0] w_node;
    logic [BW-1:0] w_blk;
    logic          took;

    assign took = req_valid && req_ready && !retry;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_node <= '0;
            w_blk  <= '0;
        end else if (took && req_op == 2'd1) begin
            w_node <= req_node;
            w_blk  <= req_blk;
        end
    end

    // R4
    inv_not_writer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid |-> inv_node != w_node);

    // R4
    inv_blk_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid |-> inv_blk == w_blk);

    // R8
    retry_same_blk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        retry |-> (req_valid && req_blk == w_blk));

    // R8
    no_inv_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && !retry) |-> !inv_valid);

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    quick_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (took && req_op != 2'd1) |=> done);
endmodule

bind ll_sharer_dir ll_dir_chk #(.NODES(NODES), .BLOCKS(BLOCKS)) u_chk (.*);

// File: tb/tb_ll_sharer_dir.sv
`timescale 1ns/1ps
module tb_ll_sharer_dir;
    localparam int PW = 3;
    localparam int BW = 2;
    localparam int NV = 25;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          req_valid;
    logic [1:0]    req_op;
    logic [PW-1:0] req_node;
    logic [BW-1:0] req_blk;
    logic          req_ready, retry, inv_valid, done;
    logic [PW-1:0] inv_node;
    logic [BW-1:0] inv_blk;

    int  total = 0;
    int  errs  = 0;
    bit  ended = 0;

    always #2.5 clk = ~clk;

    ll_sharer_dir dut (.*);

    // {op[21:20], node[19:17], blk[16:15], count[14:12], order[11:0] first in [2:0]}
    localparam logic [21:0] VEC [NV] = '{
        {2'd1, 3'd0, 2'd3, 3'd0, 12'd0},                       // R1 empty block after reset
        {2'd0, 3'd0, 2'd0, 3'd0, 12'd0},                       // R2
        {2'd0, 3'd1, 2'd0, 3'd0, 12'd0},                       // R2
        {2'd0, 3'd2, 2'd0, 3'd0, 12'd0},                       // R2
        {2'd1, 3'd3, 2'd0, 3'd3, {3'd0, 3'd0, 3'd1, 3'd2}},    // R2 R4 order 2,1,0
        {2'd0, 3'd1, 2'd0, 3'd0, 12'd0},                       // R5 chain now 1,3
        {2'd0, 3'd1, 2'd0, 3'd0, 12'd0},                       // R3 duplicate insert
        {2'd1, 3'd3, 2'd0, 3'd1, {3'd0, 3'd0, 3'd0, 3'd1}},    // R3 R4 writer skipped
        {2'd0, 3'd0, 2'd1, 3'd0, 12'd0},
        {2'd0, 3'd1, 2'd1, 3'd0, 12'd0},
        {2'd0, 3'd2, 2'd1, 3'd0, 12'd0},
        {2'd2, 3'd1, 2'd1, 3'd0, 12'd0},                       // R6 middle removal
        {2'd1, 3'd3, 2'd1, 3'd2, {3'd0, 3'd0, 3'd0, 3'd2}},    // R6 left 2,0
        {2'd0, 3'd0, 2'd2, 3'd0, 12'd0},
        {2'd0, 3'd1, 2'd2, 3'd0, 12'd0},
        {2'd0, 3'd2, 2'd2, 3'd0, 12'd0},
        {2'd2, 3'd2, 2'd2, 3'd0, 12'd0},                       // R6 head removal
        {2'd2, 3'd0, 2'd2, 3'd0, 12'd0},                       // R6 tail removal
        {2'd2, 3'd3, 2'd2, 3'd0, 12'd0},                       // R6 non-member eviction
        {2'd1, 3'd0, 2'd2, 3'd1, {3'd0, 3'd0, 3'd0, 3'd1}},    // R6 only 1 remains
        {2'd0, 3'd1, 2'd3, 3'd0, 12'd0},
        {2'd1, 3'd2, 2'd3, 3'd2, {3'd0, 3'd0, 3'd0, 3'd1}},    // R9 block 3 holds 1,0
        {2'd1, 3'd0, 2'd0, 3'd1, {3'd0, 3'd0, 3'd0, 3'd3}},    // R9 R5 block 0 holds only 3
        {2'd3, 3'd2, 2'd0, 3'd0, 12'd0},                       // R10 reserved code
        {2'd1, 3'd1, 2'd0, 3'd1, {3'd0, 3'd0, 3'd0, 3'd0}}     // R10 chain still only 0
    };

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic run_vec(input logic [21:0] v, input int idx);
        logic [PW-1:0] got [8];
        int n   = 0;
        int cyc = 0;
        @(negedge clk);
        chk(req_ready == 1'b1, "R7 ready before request", int'(req_ready), 1);
        req_valid = 1'b1;
        req_op    = v[21:20];
        req_node  = v[19:17];
        req_blk   = v[16:15];
        @(negedge clk);
        req_valid = 1'b0;
        while (!done && cyc < 40) begin
            if (inv_valid) begin
                chk(inv_blk == v[16:15], "R4 inv_blk", int'(inv_blk), int'(v[16:15]));
                if (n < 8) got[n] = inv_node;
                n++;
            end
            @(negedge clk);
            cyc++;
        end
        chk(done == 1'b1, "R7 completion seen", int'(done), 1);
        if (v[21:20] != 2'd1)
            chk(cyc == 0, "R7 done one cycle after acceptance", cyc, 0);
        chk(n == int'(v[14:12]), $sformatf("R4 inv count row %0d", idx), n, int'(v[14:12]));
        for (int k = 0; k < int'(v[14:12]) && k < n && k < 4; k++)
            chk(got[k] == v[k*3 +: 3], $sformatf("R4 inv order row %0d pos %0d", idx, k),
                int'(got[k]), int'(v[k*3 +: 3]));
    endtask

    initial begin
        #(5.0 * 150000);
        if (!ended) begin
            ended = 1;
            errs++;
            total++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, errs);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_op = '0; req_node = '0; req_blk = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset outputs
        chk(req_ready == 1'b1, "R1 req_ready", int'(req_ready), 1);
        chk(done == 1'b0, "R1 done", int'(done), 0);
        chk(inv_valid == 1'b0, "R1 inv_valid", int'(inv_valid), 0);
        chk(retry == 1'b0, "R1 retry", int'(retry), 0);

        for (int i = 0; i < NV; i++) run_vec(VEC[i], i);

        // R8 busy block during walk; block 0 becomes 2,0,1
        run_vec({2'd0, 3'd0, 2'd0, 3'd0, 12'd0}, 100);
        run_vec({2'd0, 3'd2, 2'd0, 3'd0, 12'd0}, 101);
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'd1; req_node = 3'd3; req_blk = 2'd0;
        @(negedge clk);
        chk(inv_valid && inv_node == 3'd2, "R4 first inv during walk", int'(inv_node), 2);
        req_op = 2'd0; req_node = 3'd1; req_blk = 2'd0;
        #1;
        chk(retry == 1'b1, "R8 retry for walked block", int'(retry), 1);
        chk(req_ready == 1'b1, "R8 retry consumes request", int'(req_ready), 1);
        @(negedge clk);
        chk(inv_valid && inv_node == 3'd0, "R4 second inv", int'(inv_node), 0);
        req_blk = 2'd1;
        #1;
        chk(retry == 1'b0, "R8 no retry for other block", int'(retry), 0);
        chk(req_ready == 1'b0, "R8 other block held off", int'(req_ready), 0);
        req_valid = 1'b0;
        @(negedge clk);
        chk(inv_valid && inv_node == 3'd1, "R4 third inv", int'(inv_node), 1);
        @(negedge clk);
        chk(inv_valid == 1'b0 && done == 1'b0, "R7 walk reaches null", int'(done), 0);
        @(negedge clk);
        chk(done == 1'b1, "R7 done after walk", int'(done), 1);
        // R5 R8 refused read left no trace: only 3 remains
        run_vec({2'd1, 3'd2, 2'd0, 3'd1, {3'd0, 3'd0, 3'd0, 3'd3}}, 102);

        if (!ended) begin
            ended = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, errs);
            $finish;
        end
    end
endmodule